// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-beat requests from a CPU-side synchronous port into cycles on an external parallel memory bus. The low address byte and the data byte take turns on eight shared lines, while the high address byte has lines of its own and holds steady for the whole access. Every access opens with an address phase: the low address is placed on the shared lines and an address latch enable (ALE) strobe is raised, so an external latch can capture it. The active-low read or write strobe follows. The CPU side holds only one access in flight. A one-cycle `done` pulse ends each access and, for a read, presents the returned byte.

The address space splits into a lower and an upper sector at a boundary set on the top three address bits. Each sector has its own 2-bit wait-state code, so a slow device and a fast device can share the bus. A bus keeper, enabled by a control input, weakly holds the last value seen on the shared lines whenever the controller releases them. A per-bit pull-up enable pattern is passed to the pads. Writing that pattern to zero turns the pull-ups off to save power in sleep.

States: `ST_IDLE` (no access), `ST_ADDR` (address phase, ALE high), `ST_STRB` (strobe low, wait countdown), `ST_HOLD` (extra address hold, used only with code 11) and `ST_TAIL` (strobes released, `done` high). Transitions: IDLE→ADDR on a request; ADDR→STRB always; STRB→STRB while wait cycles remain; STRB→HOLD at the end of the strobe when the code is 11; STRB→TAIL at the end of the strobe for other codes; HOLD→TAIL always; TAIL→ADDR when a new request arrives in the done cycle; TAIL→IDLE otherwise.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset `ale` is 0, `rd_n` and `wr_n` are 1, `done` is 0 and `ad_oe` is 0.
- R2: In the first cycle of an access `ale`=1, `ad_oe`=1 and `ad_o` equals addr[7:0]. `a_hi` equals addr[15:8] in every cycle from that one up to and including the `done` cycle, and ALE is high in no other cycle of the access.
- R3: The strobe (`rd_n` for a read with `we`=0, `wr_n` for a write with `we`=1) is low for 1+N consecutive cycles, starting in the cycle right after ALE. N is the selected wait code read as an unsigned number (00→0, 01→1, 10→2, 11→3).
- R4: An access lasts 3+N cycles from the ALE cycle through the `done` cycle inclusive, plus one address-hold cycle when the code is 11. `done` is high for exactly one cycle.
- R5: When addr[15:13] ≥ `sec_bnd` the access uses `ws_hi`. Otherwise it uses `ws_lo`.
- R6: While `wr_n` is low, `ad_oe`=1 and `ad_o` equals the write data. The bus is released (`ad_oe`=0) in the `done` cycle.
- R7: While `rd_n` is low, `ad_oe`=0. `rdata` in the `done` cycle equals `ad_i` as sampled on the clock edge that ends the last `rd_n`-low cycle.
- R8: ALE is high in the cycle after `done` only if `req` is high during the `done` cycle. That cycle is then the address phase of the new access. Otherwise `ale` stays 0.
- R9: A `req` raised while an access is in progress (outside its `done` cycle) is ignored and starts no access.
- R10: With `keep_en`=1 and `ad_oe`=0, `ad_keep`=1 and `ad_o` equals the last byte on the bus: the last driven byte, or the last sampled read byte. With `keep_en`=0, `ad_keep`=0.
- R11: `ad_pu` equals `pu_bits` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| sec_bnd | input | 3 | Sector boundary on addr[15:13] |
| ws_lo | input | 2 | Wait code of the lower sector |
| ws_hi | input | 2 | Wait code of the upper sector |
| keep_en | input | 1 | Bus keeper enable |
| pu_bits | input | 8 | Per-line pull-up enables |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| a_hi | output | 8 | High address byte |
| ad_o | output | 8 | Value on the shared lines (driven or kept) |
| ad_oe | output | 1 | Strong drive of the shared lines |
| ad_keep | output | 1 | Weak keeper hold of the shared lines |
| ad_i | input | 8 | Sampled shared lines |
| ad_pu | output | 8 | Pull-up enables to the pads |

## Verification
The `done` cycle of one access and the acceptance of the next request fall in the same cycle. This decides whether ALE appears right after `done`. The bench provokes it by raising a new request during randomly chosen `done` cycles and expects the next cycle to be the address phase of the new address. It also runs accesses with no follow-on request, where `ale` must stay low, and raises stray requests in the middle of accesses, which must not produce an extra ALE. Each access is judged by counting ALE, strobe and total cycles against lengths computed from the sector boundary and the wait codes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_HOLD,
        ST_TAIL
    } xb_state_t;
endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel #(
    parameter int SW  = 3,
    parameter int WSW = 2
) (
    input  logic [SW-1:0]  a_top,
    input  logic [SW-1:0]  bnd,
    input  logic [WSW-1:0] ws_lo,
    input  logic [WSW-1:0] ws_hi,
    output logic [WSW-1:0] ws_sel
);
    logic upper;

    always_comb begin
        upper  = (a_top >= bnd);
        ws_sel = upper ? ws_hi : ws_lo;
    end
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep_en,
    input  logic          drv_oe,
    input  logic [DW-1:0] drv_val,
    input  logic          smp_en,
    input  logic [DW-1:0] smp_val,
    output logic [DW-1:0] ad_o,
    output logic          ad_keep
);
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (drv_oe) begin
            last_q <= drv_val;
        end else if (smp_en) begin
            last_q <= smp_val;
        end
    end

    always_comb begin
        ad_o    = drv_oe ? drv_val : last_q;
        ad_keep = keep_en & ~drv_oe;
    end

    AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_oe && $past(!drv_oe) && $past(!smp_en)) |-> $stable(ad_o)); // R10
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int SW  = 3,
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           done,
    input  logic [SW-1:0]  sec_bnd,
    input  logic [WSW-1:0] ws_lo,
    input  logic [WSW-1:0] ws_hi,
    input  logic           keep_en,
    input  logic [DW-1:0]  pu_bits,
    output logic           ale,
    output logic           rd_n,
    output logic           wr_n,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]  ad_o,
    output logic           ad_oe,
    output logic           ad_keep,
    input  logic [DW-1:0]  ad_i,
    output logic [DW-1:0]  ad_pu
);
    localparam int HW = AW - DW;

    xb_state_t       state, nstate;
    logic [AW-1:0]   addr_q;
    logic            we_q;
    logic [DW-1:0]   wd_q;
    logic [WSW-1:0]  ws_q;
    logic [WSW-1:0]  cnt_q;
    logic [DW-1:0]   rdata_q;
    logic [WSW-1:0]  ws_sel;
    logic            accept;
    logic            strb_last;
    logic            smp_en;
    logic            drv_oe;
    logic [DW-1:0]   drv_val;

    xbus_sector_sel #(.SW(SW), .WSW(WSW)) u_sel (
        .a_top  (addr[AW-1 -: SW]),
        .bnd    (sec_bnd),
        .ws_lo  (ws_lo),
        .ws_hi  (ws_hi),
        .ws_sel (ws_sel)
    );

    always_comb begin
        accept    = req && (state == ST_IDLE || state == ST_TAIL);
        strb_last = (state == ST_STRB) && (cnt_q == '0);
        smp_en    = strb_last && !we_q;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (req) nstate = ST_ADDR;
            ST_ADDR: nstate = ST_STRB;
            ST_STRB: begin
                if (cnt_q == '0) begin
                    nstate = (ws_q == '1) ? ST_HOLD : ST_TAIL;
                end
            end
            ST_HOLD: nstate = ST_TAIL;
            ST_TAIL: nstate = req ? ST_ADDR : ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
            ws_q    <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else begin
            state <= nstate;
            if (accept) begin
                addr_q <= addr;
                we_q   <= we;
                wd_q   <= wdata;
                ws_q   <= ws_sel;
            end
            if (state == ST_ADDR) begin
                cnt_q <= ws_q;
            end else if (state == ST_STRB && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (smp_en) begin
                rdata_q <= ad_i;
            end
        end
    end

    // outputs
    always_comb begin
        ale     = (state == ST_ADDR);
        rd_n    = !((state == ST_STRB) && !we_q);
        wr_n    = !((state == ST_STRB) && we_q);
        done    = (state == ST_TAIL);
        drv_oe  = (state == ST_ADDR) || ((state == ST_STRB) && we_q);
        drv_val = (state == ST_ADDR) ? addr_q[DW-1:0] : wd_q;
        a_hi    = addr_q[AW-1 -: HW];
        rdata   = rdata_q;
        ad_oe   = drv_oe;
        ad_pu   = pu_bits;
    end

    xbus_keeper #(.DW(DW)) u_keep (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep_en (keep_en),
        .drv_oe  (drv_oe),
        .drv_val (drv_val),
        .smp_en  (smp_en),
        .smp_val (ad_i),
        .ad_o    (ad_o),
        .ad_keep (ad_keep)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe)); // R2
    AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale)); // R3
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R7
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_ALE_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && ale) |-> $past(req)); // R8
    AST_PULLUP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ad_pu == pu_bits); // R11
endmodule

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/100ps
module xbus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic [2:0]  sec_bnd = 3'd4;
    logic [1:0]  ws_lo = 2'd0;
    logic [1:0]  ws_hi = 2'd0;
    logic        keep_en = 1'b1;
    logic [7:0]  pu_bits = 8'hFF;
    logic        ale, rd_n, wr_n, ad_oe, ad_keep;
    logic [7:0]  a_hi, ad_o, ad_i, ad_pu;
    logic [7:0]  lat_lo = '0;
    logic [7:0]  exp_last = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .sec_bnd(sec_bnd),
        .ws_lo(ws_lo), .ws_hi(ws_hi), .keep_en(keep_en), .pu_bits(pu_bits),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .a_hi(a_hi), .ad_o(ad_o),
        .ad_oe(ad_oe), .ad_keep(ad_keep), .ad_i(ad_i), .ad_pu(ad_pu)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
    endfunction

    function automatic int exp_ws(input logic [15:0] a);
        return (a[15:13] >= sec_bnd) ? int'(ws_hi) : int'(ws_lo);
    endfunction

    // external latch and memory model
    always @(negedge clk) if (ale) lat_lo <= ad_o;
    assign ad_i = rd_n ? 8'hEE : mem_f({a_hi, lat_lo});

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [15:0] a, input logic [7:0] d,
                       input bit pre, input bit glitch, input bit chain,
                       input logic cw, input logic [15:0] ca, input logic [7:0] cd);
        int n, cyc, stb, ale_bad, hi_bad, ord_bad, wbad, rbad;
        n = exp_ws(a);
        if (!pre) begin
            @(negedge clk);
            req = 1'b1; we = w; addr = a; wdata = d;
            @(posedge clk);
            #1 req = 1'b0;
        end
        cyc = 0; stb = 0; ale_bad = 0; hi_bad = 0; ord_bad = 0; wbad = 0; rbad = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                chk(ale && ad_oe && ad_o == a[7:0], "R2 address phase", {ale, ad_oe, ad_o}, {2'b11, a[7:0]});
            end else if (ale) ale_bad++;
            if (a_hi != a[15:8]) hi_bad++;
            if (!rd_n || !wr_n) begin
                stb++;
                if (stb == 1 && cyc != 2) ord_bad++;
            end
            if (!wr_n && !(w && ad_oe && ad_o == d)) wbad++;
            if (!rd_n && (w || ad_oe)) rbad++;
            if (glitch && cyc == 2) begin req = 1'b1; addr = ~a; we = ~w; end
            if (glitch && cyc == 3) req = 1'b0;
            if (done) break;
            if (cyc > 12) break;
        end
        if (glitch) req = 1'b0;
        chk(cyc == 3 + n + ((n == 3) ? 1 : 0), "R4 access length", cyc, 3 + n + ((n == 3) ? 1 : 0));
        chk(stb == 1 + n, "R3/R5 strobe width", stb, 1 + n);
        chk(ord_bad == 0, "R3 strobe follows ALE", ord_bad, 0);
        chk(ale_bad == 0 && hi_bad == 0, "R2 ALE once, high address held", ale_bad + hi_bad, 0);
        if (w) begin
            chk(wbad == 0, "R6 write data driven", wbad, 0);
            chk(!ad_oe, "R6 released at done", ad_oe, 0);
            exp_last = d;
        end else begin
            chk(rbad == 0, "R7 bus released on read", rbad, 0);
            chk(rdata == mem_f(a), "R7 read data", rdata, mem_f(a));
            exp_last = mem_f(a);
        end
        if (chain) begin
            req = 1'b1; we = cw; addr = ca; wdata = cd;
            @(posedge clk);
            #1 req = 1'b0;
        end else begin
            @(negedge clk);
            chk(!ale, glitch ? "R9 stray request ignored" : "R8 no ALE without request", ale, 0);
            chk(!ad_oe && ad_keep == keep_en && (!keep_en || ad_o == exp_last),
                "R10 keeper", {ad_keep, ad_o}, {keep_en, exp_last});
            chk(ad_pu == pu_bits, "R11 pull-up mirror", ad_pu, pu_bits);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic        cw, nw;
        logic [15:0] ca, na;
        logic [7:0]  cd, nd;
        bit          pre, ch;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !done && !ad_oe, "R1 reset state",
            {ale, rd_n, wr_n, done, ad_oe}, 5'b01100);
        rst_n = 1'b1;

        // directed: each wait code, sector boundary edges
        sec_bnd = 3'd4; ws_lo = 2'd0; ws_hi = 2'd3;
        acc(1'b1, 16'h7FFF, 8'h3C, 0, 0, 0, 0, '0, '0);  // below boundary, code 00
        acc(1'b0, 16'h8000, 8'h00, 0, 0, 0, 0, '0, '0);  // at boundary, code 11
        ws_lo = 2'd1; ws_hi = 2'd2;
        acc(1'b0, 16'h1234, 8'h00, 0, 0, 0, 0, '0, '0);  // R5 lower
        acc(1'b1, 16'hE0A5, 8'hC3, 0, 0, 0, 0, '0, '0);  // R5 upper
        sec_bnd = 3'd0;
        acc(1'b0, 16'h0001, 8'h00, 0, 0, 0, 0, '0, '0);  // R5 boundary zero: all upper
        // back-to-back R8
        acc(1'b1, 16'h2222, 8'h11, 0, 0, 1, 1'b0, 16'hA0B0, 8'h00);
        acc(1'b0, 16'hA0B0, 8'h00, 1, 0, 0, 0, '0, '0);
        // stray request R9
        ws_hi = 2'd0;
        acc(1'b0, 16'h4444, 8'h00, 0, 1, 0, 0, '0, '0);
        keep_en = 1'b0; pu_bits = 8'h00;
        acc(1'b1, 16'h5A5A, 8'h77, 0, 0, 0, 0, '0, '0);  // R10 keeper off, R11

        // constrained random
        pre = 0;
        cw = 1'b0; ca = '0; cd = '0;
        for (int i = 0; i < 60; i++) begin
            if (!pre) begin
                sec_bnd = 3'($urandom_range(0, 7));
                ws_lo   = 2'($urandom_range(0, 3));
                ws_hi   = 2'($urandom_range(0, 3));
                keep_en = 1'($urandom_range(0, 1));
                pu_bits = 8'($urandom);
                cw = 1'($urandom_range(0, 1));
                ca = 16'($urandom);
                cd = 8'($urandom);
            end
            ch = ($urandom_range(0, 3) == 0) && (i != 59);
            nw = 1'($urandom_range(0, 1));
            na = 16'($urandom);
            nd = 8'($urandom);
            acc(cw, ca, cd, pre, (!ch && $urandom_range(0, 4) == 0), ch, nw, na, nd);
            pre = ch;
            cw = nw; ca = na; cd = nd;
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule